// File: doc/BRIEF.md
# Keyed Watchdog Timer with Power-of-Two Scaler

This block is a watchdog timer behind a small 32-bit register bus. A free-running counter advances on an external low-rate tick enable (one tick every 32 microseconds at a 31250 Hz tick rate). It advances when enabled either unconditionally or only while the core reports itself awake. The counter is shifted right by a 4-bit scale field, and that scaled value is compared with a 16-bit threshold. A match sets a sticky pending flag. The flag drives the interrupt line, and it also drives a reset request when reset generation is enabled. A match can optionally return the counter to zero.

Software guards every register change with a one-shot key. The value 0x0051F15E must be written to the key register, and the very next bus write is the only one that may take effect. That next write also spends the key, whatever its target or value. Software restarts the count by writing the feed word 0x0D09F00D to the feed register while the key is active. Reads are combinational and never touch the key.

Top module: `keyed_wdog`

## Requirements
- R1: After reset the configuration register (0x00) reads 0, the count (0x08) reads 0, the compare register (0x20) reads 0x0000FFFF, the key register (0x1C) reads 0, and both irq and rst_req are low.
- R2: A write of 0x0051F15E to the key register (0x1C) makes it read 1. A write of any other value to the key register makes it read 0. A write to any other address returns the key register to 0.
- R3: A write to the configuration, compare or feed register that is not immediately preceded by a valid key write leaves that register and the counter unchanged.
- R4: An unlocked write of 0x0D09F00D to the feed register (0x18) clears the counter to 0. An unlocked write of any other value there leaves the counter unchanged.
- R5: The configuration word has the scale in bits [3:0], reset-enable in bit 8, zero-on-match in bit 9, always-enable in bit 12, awake-enable in bit 13 and the pending flag in bit 28. Other bits read 0.
- R6: On each cycle with tick_en high, the counter increments if always-enable is set, or if awake-enable is set and core_awake is high. Otherwise the counter holds its value.
- R7: The scaled-count register (0x10) reads the counter shifted right by the scale value.
- R8: When the scaled count is greater than or equal to the compare value, the pending flag and irq are set on the next clock edge.
- R9: When zero-on-match is set, a match returns the counter to 0 on the next edge. This takes priority over a tick.
- R10: The pending flag stays set until an unlocked configuration write carries 0 in bit 28. A match in the same cycle as that write keeps the flag set.
- R11: rst_req is high exactly while the pending flag and reset-enable are both set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| tick_en | input | 1 | Low-rate timebase tick, one cycle wide |
| core_awake | input | 1 | High while the core is awake |
| irq | output | 1 | Pending flag (interrupt) |
| rst_req | output | 1 | System reset request |

## Verification
The assertions check, on every cycle, that any non-key write spends the key, that a locked compare write changes nothing, and that the counter holds whenever it is neither ticking nor cleared. They also check that a match sets the pending flag on the next edge, that the flag does not drop without an unlocked configuration write, that a zero-on-match hit zeroes the counter, and that a reset request is never raised without a pending flag. Only the bench scenarios can show the register field positions and the feed and key magic values. The same holds for the awake-gated counting, the scaled readback at a nonzero scale, and the case where a match wins over a clearing write in the same cycle.

// File: rtl/keyed_wdog_pkg.sv
package keyed_wdog_pkg;

    localparam logic [31:0] WD_KEY_VAL  = 32'h0051_F15E;
    localparam logic [31:0] WD_FEED_VAL = 32'h0D09_F00D;

    localparam logic [7:0] OFS_CFG    = 8'h00;
    localparam logic [7:0] OFS_COUNT  = 8'h08;
    localparam logic [7:0] OFS_SCALED = 8'h10;
    localparam logic [7:0] OFS_FEED   = 8'h18;
    localparam logic [7:0] OFS_KEY    = 8'h1C;
    localparam logic [7:0] OFS_CMP    = 8'h20;

    localparam int BIT_RST_EN   = 8;
    localparam int BIT_ZERO_CMP = 9;
    localparam int BIT_EN_ALW   = 12;
    localparam int BIT_EN_AWAKE = 13;
    localparam int BIT_PEND     = 28;

    typedef struct packed {
        logic       rst_en;
        logic       zero_cmp;
        logic       en_always;
        logic       en_awake;
        logic       pend;
        logic [3:0] scale;
    } wd_cfg_t;

endpackage

// File: rtl/wdog_unlock.sv
module wdog_unlock (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        key_sel,
    input  logic [31:0] wdata,
    output logic        unlocked
);
    import keyed_wdog_pkg::*;

    typedef struct packed {
        logic open;
    } lk_state_t;

    lk_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.open = key_sel && (wdata == WD_KEY_VAL);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign unlocked = st_q.open;

    // R2: any write to a non-key address spends the key
    a_r2_key_consumed: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !key_sel) |=> !unlocked);

endmodule

// File: rtl/wdog_cfg.sv
module wdog_cfg #(
    parameter int CMP_W   = 16,
    parameter int SCALE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic               cmp_wr,
    input  logic [SCALE_W-1:0] wr_scale,
    input  logic               wr_rst_en,
    input  logic               wr_zero_cmp,
    input  logic               wr_en_always,
    input  logic               wr_en_awake,
    input  logic               wr_pend,
    input  logic [CMP_W-1:0]   wr_cmp,
    input  logic               match,
    output logic [SCALE_W-1:0] scale,
    output logic               rst_en,
    output logic               zero_cmp,
    output logic               en_always,
    output logic               en_awake,
    output logic               pend,
    output logic [CMP_W-1:0]   cmp
);

    typedef struct packed {
        logic [SCALE_W-1:0] scale;
        logic               rst_en;
        logic               zero_cmp;
        logic               en_always;
        logic               en_awake;
        logic               pend;
        logic [CMP_W-1:0]   cmp;
    } cf_state_t;

    cf_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_wr) begin
            st_d.scale     = wr_scale;
            st_d.rst_en    = wr_rst_en;
            st_d.zero_cmp  = wr_zero_cmp;
            st_d.en_always = wr_en_always;
            st_d.en_awake  = wr_en_awake;
            st_d.pend      = wr_pend;
        end
        if (cmp_wr) begin
            st_d.cmp = wr_cmp;
        end
        if (match) begin
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.cmp <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign scale     = st_q.scale;
    assign rst_en    = st_q.rst_en;
    assign zero_cmp  = st_q.zero_cmp;
    assign en_always = st_q.en_always;
    assign en_awake  = st_q.en_awake;
    assign pend      = st_q.pend;
    assign cmp       = st_q.cmp;

    // R8: a match raises the pending flag on the next edge
    a_r8_match_sets_pend: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> pend);

    // R10: the flag only falls through a configuration write
    a_r10_pend_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !cfg_wr) |=> pend);

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int CNT_W   = 31,
    parameter int CMP_W   = 16,
    parameter int SCALE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               en_always,
    input  logic               en_awake,
    input  logic               core_awake,
    input  logic               feed_clr,
    input  logic               zero_cmp,
    input  logic [SCALE_W-1:0] scale,
    input  logic [CMP_W-1:0]   cmp,
    output logic [CNT_W-1:0]   count,
    output logic [CNT_W-1:0]   scaled,
    output logic               match
);
    localparam int PAD_W = CNT_W - CMP_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ct_state_t;

    ct_state_t st_d, st_q;
    logic      advance;

    assign scaled  = st_q.cnt >> scale;
    assign match   = scaled >= {{PAD_W{1'b0}}, cmp};
    assign advance = tick && (en_always || (en_awake && core_awake));

    always_comb begin
        st_d = st_q;
        if (feed_clr) begin
            st_d.cnt = '0;
        end else if (zero_cmp && match) begin
            st_d.cnt = '0;
        end else if (advance) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;

    // R6: with no tick the counter only moves through a clear
    a_r6_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !feed_clr && !(zero_cmp && match)) |=> $stable(count));

    // R9: zero-on-match returns the counter to zero
    a_r9_zero_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_cmp && match) |=> (count == '0));

    // R4: a feed clears the counter
    a_r4_feed_clears: assert property (@(posedge clk) disable iff (!rst_n)
        feed_clr |=> (count == '0));

endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog #(
    parameter int ADDR_W  = 6,
    parameter int CNT_W   = 31,
    parameter int CMP_W   = 16,
    parameter int SCALE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              tick_en,
    input  logic              core_awake,
    output logic              irq,
    output logic              rst_req
);
    import keyed_wdog_pkg::*;

    logic               sel_cfg, sel_cnt, sel_scl, sel_feed, sel_key, sel_cmp;
    logic               unlocked, wr_ok, feed_clr;
    logic [SCALE_W-1:0] scale;
    logic               rst_en, zero_cmp, en_always, en_awake, pend;
    logic [CMP_W-1:0]   cmp;
    logic [CNT_W-1:0]   count, scaled;
    logic               match;

    assign sel_cfg  = bus_addr == OFS_CFG[ADDR_W-1:0];
    assign sel_cnt  = bus_addr == OFS_COUNT[ADDR_W-1:0];
    assign sel_scl  = bus_addr == OFS_SCALED[ADDR_W-1:0];
    assign sel_feed = bus_addr == OFS_FEED[ADDR_W-1:0];
    assign sel_key  = bus_addr == OFS_KEY[ADDR_W-1:0];
    assign sel_cmp  = bus_addr == OFS_CMP[ADDR_W-1:0];

    assign wr_ok    = bus_we && unlocked;
    assign feed_clr = wr_ok && sel_feed && (bus_wdata == WD_FEED_VAL);

    wdog_unlock u_unlock (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_we),
        .key_sel  (sel_key),
        .wdata    (bus_wdata),
        .unlocked (unlocked)
    );

    wdog_cfg #(.CMP_W(CMP_W), .SCALE_W(SCALE_W)) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wr       (wr_ok && sel_cfg),
        .cmp_wr       (wr_ok && sel_cmp),
        .wr_scale     (bus_wdata[SCALE_W-1:0]),
        .wr_rst_en    (bus_wdata[BIT_RST_EN]),
        .wr_zero_cmp  (bus_wdata[BIT_ZERO_CMP]),
        .wr_en_always (bus_wdata[BIT_EN_ALW]),
        .wr_en_awake  (bus_wdata[BIT_EN_AWAKE]),
        .wr_pend      (bus_wdata[BIT_PEND]),
        .wr_cmp       (bus_wdata[CMP_W-1:0]),
        .match        (match),
        .scale        (scale),
        .rst_en       (rst_en),
        .zero_cmp     (zero_cmp),
        .en_always    (en_always),
        .en_awake     (en_awake),
        .pend         (pend),
        .cmp          (cmp)
    );

    wdog_counter #(.CNT_W(CNT_W), .CMP_W(CMP_W), .SCALE_W(SCALE_W)) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick_en),
        .en_always  (en_always),
        .en_awake   (en_awake),
        .core_awake (core_awake),
        .feed_clr   (feed_clr),
        .zero_cmp   (zero_cmp),
        .scale      (scale),
        .cmp        (cmp),
        .count      (count),
        .scaled     (scaled),
        .match      (match)
    );

    always_comb begin
        bus_rdata = '0;
        if (sel_cfg) begin
            bus_rdata[SCALE_W-1:0]  = scale;
            bus_rdata[BIT_RST_EN]   = rst_en;
            bus_rdata[BIT_ZERO_CMP] = zero_cmp;
            bus_rdata[BIT_EN_ALW]   = en_always;
            bus_rdata[BIT_EN_AWAKE] = en_awake;
            bus_rdata[BIT_PEND]     = pend;
        end else if (sel_cnt) begin
            bus_rdata[CNT_W-1:0] = count;
        end else if (sel_scl) begin
            bus_rdata[CNT_W-1:0] = scaled;
        end else if (sel_key) begin
            bus_rdata[0] = unlocked;
        end else if (sel_cmp) begin
            bus_rdata[CMP_W-1:0] = cmp;
        end
    end

    assign irq     = pend;
    assign rst_req = pend && rst_en;

    // R3: a compare write without the key changes nothing
    a_r3_locked_cmp: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !unlocked && sel_cmp) |=> $stable(cmp));

    // R11: no reset request without a pending flag
    a_r11_req_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> irq);

endmodule

// File: tb/sim_keyed_wdog.sv
module sim_keyed_wdog;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_en = 1'b0;
    logic        core_awake = 1'b0;
    logic        irq, rst_req;

    int errs = 0;
    int checks = 0;

    localparam logic [5:0] A_CFG = 6'h00, A_CNT = 6'h08, A_SCL = 6'h10,
                           A_FEED = 6'h18, A_KEY = 6'h1C, A_CMP = 6'h20;
    localparam logic [31:0] KEY = 32'h0051_F15E, FOOD = 32'h0D09_F00D;

    always #10 clk = ~clk;

    keyed_wdog u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_en(tick_en),
        .core_awake(core_awake), .irq(irq), .rst_req(rst_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic uwr(input logic [5:0] a, input logic [31:0] d);
        wr(A_KEY, KEY);
        wr(a, d);
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_en = 1'b1;
            @(negedge clk);
            tick_en = 1'b0;
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_CFG, v); check("R1 cfg", v, 32'h0);
        rd(A_CNT, v); check("R1 count", v, 32'h0);
        rd(A_CMP, v); check("R1 cmp", v, 32'h0000_FFFF);
        rd(A_KEY, v); check("R1 key", v, 32'h0);
        check("R1 irq", {31'h0, irq}, 32'h0);
        check("R1 rst_req", {31'h0, rst_req}, 32'h0);
    endtask

    task automatic t_lock();
        logic [31:0] v;
        wr(A_CMP, 32'h0000_0005);
        rd(A_CMP, v); check("R3 locked cmp", v, 32'h0000_FFFF);
        wr(A_CFG, 32'h0000_1003);
        rd(A_CFG, v); check("R3 locked cfg", v, 32'h0);
        wr(A_KEY, KEY);
        rd(A_KEY, v); check("R2 key open", v, 32'h1);
        step();
        rd(A_KEY, v); check("R2 key held while idle", v, 32'h1);
        wr(A_CNT, 32'h0);
        rd(A_KEY, v); check("R2 key spent by other addr", v, 32'h0);
        wr(A_KEY, KEY);
        wr(A_KEY, 32'h0000_1234);
        rd(A_KEY, v); check("R2 wrong key", v, 32'h0);
    endtask

    task automatic t_count();
        logic [31:0] v;
        uwr(A_CFG, 32'h0000_1000);
        ticks(5);
        rd(A_CNT, v); check("R6 always count", v, 32'd5);
        uwr(A_CFG, 32'h0000_2000);
        core_awake = 1'b0;
        ticks(3);
        rd(A_CNT, v); check("R6 awake gated off", v, 32'd5);
        core_awake = 1'b1;
        ticks(3);
        rd(A_CNT, v); check("R6 awake counting", v, 32'd8);
        uwr(A_CFG, 32'h0);
        ticks(2);
        rd(A_CNT, v); check("R6 both disabled", v, 32'd8);
        core_awake = 1'b0;
    endtask

    task automatic t_feed();
        logic [31:0] v;
        uwr(A_FEED, 32'h0D09_F00E);
        rd(A_CNT, v); check("R4 bad feed", v, 32'd8);
        rd(A_KEY, v); check("R4 bad feed spends key", v, 32'h0);
        wr(A_FEED, FOOD);
        rd(A_CNT, v); check("R3 locked feed", v, 32'd8);
        uwr(A_FEED, FOOD);
        rd(A_CNT, v); check("R4 good feed", v, 32'd0);
    endtask

    task automatic t_scale();
        logic [31:0] v;
        uwr(A_CFG, 32'h0000_1002);
        rd(A_CFG, v); check("R5 cfg readback", v, 32'h0000_1002);
        ticks(13);
        rd(A_CNT, v); check("R7 raw", v, 32'd13);
        rd(A_SCL, v); check("R7 scaled", v, 32'd3);
        check("R8 no early irq", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_match();
        logic [31:0] v;
        uwr(A_FEED, FOOD);
        uwr(A_CMP, 32'hABCD_0004);
        rd(A_CMP, v); check("R5 cmp width", v, 32'h0000_0004);
        uwr(A_CFG, 32'h0000_1001);
        ticks(7);
        step();
        check("R8 below threshold", {31'h0, irq}, 32'h0);
        ticks(1);
        step();
        rd(A_CFG, v); check("R8 pend bit 28", v, 32'h1000_1001);
        check("R8 irq", {31'h0, irq}, 32'h1);
        check("R11 no req without enable", {31'h0, rst_req}, 32'h0);
        uwr(A_FEED, FOOD);
        step();
        check("R10 sticky after feed", {31'h0, irq}, 32'h1);
        uwr(A_CFG, 32'h0000_1001);
        check("R10 cleared", {31'h0, irq}, 32'h0);
        uwr(A_CFG, 32'h0000_1101);
        ticks(8);
        step();
        check("R11 req", {31'h0, rst_req}, 32'h1);
        uwr(A_CFG, 32'h0000_0100);
        check("R10 match wins over clear", {31'h0, irq}, 32'h1);
        uwr(A_FEED, FOOD);
        uwr(A_CFG, 32'h0);
        check("R10 clear after feed", {31'h0, irq}, 32'h0);
        check("R11 req drops", {31'h0, rst_req}, 32'h0);
    endtask

    task automatic t_zero();
        logic [31:0] v;
        uwr(A_CMP, 32'h3);
        uwr(A_CFG, 32'h0000_1200);
        ticks(3);
        step();
        rd(A_CNT, v); check("R9 zeroed", v, 32'd0);
        check("R9 irq", {31'h0, irq}, 32'h1);
        ticks(2);
        rd(A_CNT, v); check("R9 restarts", v, 32'd2);
    endtask

    initial begin
        #(20 * 200000);
        errs++;
        $display("FAIL watchdog timeout actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        t_reset();
        t_lock();
        t_count();
        t_feed();
        t_scale();
        t_match();
        t_zero();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule